// File: doc/BRIEF.md
# Prioritized Interrupt Selector with Masking

This block decides, every clock, which pending exception or interrupt request a core should take next. Three sources have fixed priorities that outrank everything else: the reset request (-3), the non-maskable interrupt (-2) and hard fault (-1). Behind them sit `NUM_IRQ` request lines. Software gives each line an 8-bit priority, where a smaller number means more urgent and 0 is the most urgent.

Each line has an enable bit. Software sets it through a write-one-to-set port and clears it through a write-one-to-clear port. There are three mask registers:
- a global disable, which blocks every configurable line;
- a fault-level disable, which blocks hard fault as well as every configurable line;
- a priority threshold, which blocks lines whose priority number is at or above a nonzero limit.

The mask registers and the line priorities are written through a small synchronous port. Each write has an address, data and a write enable.

The result is registered. It consists of a take strobe, the index of the winning source and its effective priority as a signed value. Source indices are 0 for reset, 1 for the non-maskable interrupt, 2 for hard fault and 3+k for line k. The configuration address map uses the same numbers: 0 is the global disable, 1 is the fault-level disable, 2 is the threshold, and 3+k is the priority of line k.

Top module: `irq_selector`

## Requirements
- R1: After reset, `take`, `winIdx` and `winPrio` are 0. All line enables, mask registers and line priorities are 0, so an active line request is not taken until its enable is set.
- R2: The fixed sources win in this order: reset request (index 0, priority -3), then a pending non-maskable interrupt (index 1, priority -2), then hard fault (index 2, priority -1). Any of them beats every configurable line.
- R3: Among eligible lines, the one with the smallest programmed priority number wins. It is reported with index 3+k and with its programmed priority as the effective priority.
- R4: When several eligible lines share the smallest priority number, the line with the lowest index wins.
- R5: Writing bit 0 of address 0 to 1 blocks all configurable lines, while reset, non-maskable interrupt and hard fault are still taken. Writing it back to 0 lifts the block.
- R6: Writing bit 0 of address 1 to 1 blocks hard fault and all configurable lines, while reset and the non-maskable interrupt are still taken.
- R7: A nonzero value N written to address 2 blocks every line whose priority number is N or greater. A value of 0 disables threshold masking.
- R8: A 1 on bit k of `setEn` sets the enable of line k and a 1 on bit k of `clrEn` clears it. Zero bits change nothing. If both ports carry a 1 on the same bit in one cycle, clear wins.
- R9: A rising edge on `nmiReq` makes the non-maskable interrupt pending from the next clock. It is taken for one cycle and then cleared, even if `nmiReq` stays high. A new rising edge is needed to take it again. While a reset request holds the pending interrupt off, it stays pending.
- R10: `take`, `winIdx` and `winPrio` reflect the requests sampled at the previous clock edge. `take` is high in every cycle that follows a sampled eligible source. When `take` is 0, `winIdx` and `winPrio` are 0.
- R11: A write to address 3+k sets the priority of line k from `cfgData`. Writes to addresses above the last line have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of the block |
| rstReq | input | 1 | Reset exception request, level |
| nmiReq | input | 1 | Non-maskable interrupt request, rising-edge detected |
| faultReq | input | 1 | Hard fault request, level |
| irqReq | input | NUM_IRQ | Configurable line requests, level |
| setEn | input | NUM_IRQ | Write-one-to-set line enables |
| clrEn | input | NUM_IRQ | Write-one-to-clear line enables |
| cfgWe | input | 1 | Configuration write enable |
| cfgAddr | input | IDX_W | Configuration address (0 global, 1 fault, 2 threshold, 3+k line priority) |
| cfgData | input | PRIO_W | Configuration write data |
| take | output | 1 | A source was selected in the previous cycle |
| winIdx | output | IDX_W | Winning source index |
| winPrio | output | PRIO_W+1 | Signed effective priority of the winner |

## Verification
The selection is driven with different mixes of active lines:
- Disjoint priorities show that the smallest number wins.
- Equal priorities show that lines are ordered by index.
- All lines active at once checks the arbitration with the full request vector.

Each fixed source is then stacked on top of line traffic to separate the three tiers. A held non-maskable request shows the difference between edge and level capture. Each mask is written while both lines and faults request, so that a reach that is too wide or too narrow shows up. Simultaneous set and clear on an enable bit, zero writes, and writes to unused addresses check the enable and configuration ports.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;

  // Source numbering, also used as configuration addresses
  localparam int SRC_RESET = 0;
  localparam int SRC_NMI   = 1;
  localparam int SRC_FAULT = 2;
  localparam int SRC_LINE0 = 3;

  // Fixed priorities of the non-configurable tier
  localparam int PRIO_RESET = -3;
  localparam int PRIO_NMI   = -2;
  localparam int PRIO_FAULT = -1;

  // Write strobes from the control side to the datapath
  typedef struct packed {
    logic wrGlobal;
    logic wrFault;
    logic wrThresh;
    logic wrPrio;
  } cfgStrobeT;

endpackage

// File: rtl/irqsel_ctrl.sv
module irqsel_ctrl import irqsel_pkg::*; #(
  parameter int NUM_IRQ = 8,
  localparam int NUM_SRC = NUM_IRQ + SRC_LINE0,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               nmiReq,
  input  logic [NUM_IRQ-1:0] setEn,
  input  logic [NUM_IRQ-1:0] clrEn,
  input  logic               cfgWe,
  input  logic [IDX_W-1:0]   cfgAddr,
  input  logic               nmiTaken,
  output cfgStrobeT          strobe,
  output logic [NUM_IRQ-1:0] lineEn,
  output logic               nmiPend
);

  logic nmiPrev;
  logic nmiRise;

  // Address decode into write strobes
  always_comb begin
    strobe.wrGlobal = cfgWe && (cfgAddr == IDX_W'(SRC_RESET));
    strobe.wrFault  = cfgWe && (cfgAddr == IDX_W'(SRC_NMI));
    strobe.wrThresh = cfgWe && (cfgAddr == IDX_W'(SRC_FAULT));
    strobe.wrPrio   = cfgWe && (cfgAddr >= IDX_W'(SRC_LINE0))
                            && (32'(cfgAddr) < NUM_SRC);
  end

  // Enable bits: clear takes precedence over set
  always_ff @(posedge clk) begin
    if (!rstN) lineEn <= '0;
    else       lineEn <= (lineEn | setEn) & ~clrEn;
  end

  // Edge capture of the non-maskable request
  assign nmiRise = nmiReq & ~nmiPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiPrev <= 1'b0;
      nmiPend <= 1'b0;
    end else begin
      nmiPrev <= nmiReq;
      nmiPend <= nmiRise | (nmiPend & ~nmiTaken);
    end
  end

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clrEn != '0) |=> ((lineEn & $past(clrEn)) == '0));

  assert_set_sticks_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((setEn & ~clrEn) != '0) |=> ((lineEn & $past(setEn & ~clrEn)) == $past(setEn & ~clrEn)));

  assert_zero_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (setEn == '0 && clrEn == '0) |=> $stable(lineEn));

  assert_nmi_once_R9: assert property (@(posedge clk) disable iff (!rstN)
    (nmiPend && nmiTaken && !nmiRise) |=> !nmiPend);

endmodule

// File: rtl/irqsel_dp.sv
module irqsel_dp import irqsel_pkg::*; #(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W = 8,
  localparam int NUM_SRC = NUM_IRQ + SRC_LINE0,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cfgStrobeT                strobe,
  input  logic [IDX_W-1:0]         cfgAddr,
  input  logic [PRIO_W-1:0]        cfgData,
  input  logic                     rstReq,
  input  logic                     nmiPend,
  input  logic                     faultReq,
  input  logic [NUM_IRQ-1:0]       irqReq,
  input  logic [NUM_IRQ-1:0]       lineEn,
  output logic                     nmiTaken,
  output logic                     take,
  output logic [IDX_W-1:0]         winIdx,
  output logic signed [PRIO_W:0]   winPrio
);

  logic                   globalDis;
  logic                   faultDis;
  logic [PRIO_W-1:0]      thresh;
  logic [PRIO_W-1:0]      prioReg [NUM_IRQ];
  logic [NUM_IRQ-1:0]     lineElig;
  logic                   lineHit;
  logic [IDX_W-1:0]       lineBest;
  logic [PRIO_W-1:0]      prioBest;
  logic                   selValid;
  logic [IDX_W-1:0]       selIdx;
  logic signed [PRIO_W:0] selPrio;

  // Mask registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalDis <= 1'b0;
      faultDis  <= 1'b0;
      thresh    <= '0;
    end else begin
      if (strobe.wrGlobal) globalDis <= cfgData[0];
      if (strobe.wrFault)  faultDis  <= cfgData[0];
      if (strobe.wrThresh) thresh    <= cfgData;
    end
  end

  // Per-line priority storage and eligibility
  for (genvar k = 0; k < NUM_IRQ; k++) begin : gLine
    always_ff @(posedge clk) begin
      if (!rstN) prioReg[k] <= '0;
      else if (strobe.wrPrio && cfgAddr == IDX_W'(k + SRC_LINE0)) prioReg[k] <= cfgData;
    end
    assign lineElig[k] = irqReq[k] & lineEn[k] & ~globalDis & ~faultDis
                       & ((thresh == '0) | (prioReg[k] < thresh));
  end

  // Smallest number wins; strict compare keeps the lowest index on ties
  always_comb begin
    lineHit  = 1'b0;
    lineBest = '0;
    prioBest = '0;
    for (int k = 0; k < NUM_IRQ; k++) begin
      if (lineElig[k] && (!lineHit || prioReg[k] < prioBest)) begin
        lineHit  = 1'b1;
        lineBest = IDX_W'(k + SRC_LINE0);
        prioBest = prioReg[k];
      end
    end
  end

  // Fixed tier ahead of the configurable tier
  always_comb begin
    selValid = 1'b1;
    selIdx   = '0;
    selPrio  = '0;
    if (rstReq) begin
      selIdx  = IDX_W'(SRC_RESET);
      selPrio = (PRIO_W+1)'(PRIO_RESET);
    end else if (nmiPend) begin
      selIdx  = IDX_W'(SRC_NMI);
      selPrio = (PRIO_W+1)'(PRIO_NMI);
    end else if (faultReq && !faultDis) begin
      selIdx  = IDX_W'(SRC_FAULT);
      selPrio = (PRIO_W+1)'(PRIO_FAULT);
    end else if (lineHit) begin
      selIdx  = lineBest;
      selPrio = {1'b0, prioBest};
    end else begin
      selValid = 1'b0;
    end
  end

  assign nmiTaken = nmiPend && !rstReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      take    <= 1'b0;
      winIdx  <= '0;
      winPrio <= '0;
    end else begin
      take    <= selValid;
      winIdx  <= selIdx;
      winPrio <= selPrio;
    end
  end

  assert_reset_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> (take && winIdx == IDX_W'(SRC_RESET) && winPrio == (PRIO_W+1)'(PRIO_RESET)));

  assert_global_block_R5: assert property (@(posedge clk) disable iff (!rstN)
    globalDis |=> !(take && winIdx >= IDX_W'(SRC_LINE0)));

  assert_fault_block_R6: assert property (@(posedge clk) disable iff (!rstN)
    faultDis |=> !(take && winIdx >= IDX_W'(SRC_FAULT)));

  assert_threshold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (thresh != '0) |=> !(take && winIdx >= IDX_W'(SRC_LINE0)
                         && winPrio[PRIO_W-1:0] >= $past(thresh)));

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !take |-> (winIdx == '0 && winPrio == '0));

endmodule

// File: rtl/irq_selector.sv
module irq_selector import irqsel_pkg::*; #(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W = 8,
  localparam int NUM_SRC = NUM_IRQ + SRC_LINE0,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rstReq,
  input  logic                   nmiReq,
  input  logic                   faultReq,
  input  logic [NUM_IRQ-1:0]     irqReq,
  input  logic [NUM_IRQ-1:0]     setEn,
  input  logic [NUM_IRQ-1:0]     clrEn,
  input  logic                   cfgWe,
  input  logic [IDX_W-1:0]       cfgAddr,
  input  logic [PRIO_W-1:0]      cfgData,
  output logic                   take,
  output logic [IDX_W-1:0]       winIdx,
  output logic signed [PRIO_W:0] winPrio
);

  cfgStrobeT          strobe;
  logic [NUM_IRQ-1:0] lineEn;
  logic               nmiPend;
  logic               nmiTaken;

  irqsel_ctrl #(.NUM_IRQ(NUM_IRQ)) i_ctrl (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .setEn(setEn), .clrEn(clrEn),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .nmiTaken(nmiTaken),
    .strobe(strobe), .lineEn(lineEn), .nmiPend(nmiPend)
  );

  irqsel_dp #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .rstReq(rstReq), .nmiPend(nmiPend), .faultReq(faultReq), .irqReq(irqReq),
    .lineEn(lineEn), .nmiTaken(nmiTaken),
    .take(take), .winIdx(winIdx), .winPrio(winPrio)
  );

endmodule

// File: tb/test_irq_selector.sv
`timescale 1ns/1ps
module test_irq_selector;
  localparam int NUM_IRQ = 8;
  localparam int PRIO_W  = 8;
  localparam int IDX_W   = $clog2(NUM_IRQ + 3);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rstReq = 1'b0, nmiReq = 1'b0, faultReq = 1'b0;
  logic [NUM_IRQ-1:0] irqReq = '0, setEn = '0, clrEn = '0;
  logic cfgWe = 1'b0;
  logic [IDX_W-1:0] cfgAddr = '0;
  logic [PRIO_W-1:0] cfgData = '0;
  logic take;
  logic [IDX_W-1:0] winIdx;
  logic signed [PRIO_W:0] winPrio;

  irq_selector #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) i_irq_selector (
    .clk(clk), .rstN(rstN), .rstReq(rstReq), .nmiReq(nmiReq), .faultReq(faultReq),
    .irqReq(irqReq), .setEn(setEn), .clrEn(clrEn), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .take(take), .winIdx(winIdx), .winPrio(winPrio)
  );

  always #2.5 clk = ~clk;

  // Reference state, built from the requirements
  bit [NUM_IRQ-1:0] mEn;
  bit mGlob, mFault, mNmiPend, mNmiPrev;
  int mThr;
  int mPrio [NUM_IRQ];

  // Scoreboard
  int expTakeQ[$];
  int expIdxQ[$];
  int expPrioQ[$];
  string expTagQ[$];
  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  task automatic step(input bit r, input bit n, input bit f, input bit [NUM_IRQ-1:0] irq,
                      input bit [NUM_IRQ-1:0] s, input bit [NUM_IRQ-1:0] c,
                      input bit we, input int addr, input int data, input string tag);
    int eTake, eIdx, ePrio;
    bit hit;
    @(negedge clk);
    rstReq = r; nmiReq = n; faultReq = f; irqReq = irq;
    setEn = s; clrEn = c; cfgWe = we;
    cfgAddr = IDX_W'(addr); cfgData = PRIO_W'(data);
    eTake = 1; eIdx = 0; ePrio = 0; hit = 1'b0;
    if (r) begin eIdx = 0; ePrio = -3; end
    else if (mNmiPend) begin eIdx = 1; ePrio = -2; end
    else if (f && !mFault) begin eIdx = 2; ePrio = -1; end
    else begin
      for (int k = 0; k < NUM_IRQ; k++) begin
        if (irq[k] && mEn[k] && !mGlob && !mFault && (mThr == 0 || mPrio[k] < mThr)
            && (!hit || mPrio[k] < ePrio)) begin
          hit = 1'b1; eIdx = k + 3; ePrio = mPrio[k];
        end
      end
      if (!hit) begin eTake = 0; eIdx = 0; ePrio = 0; end
    end
    expTakeQ.push_back(eTake);
    expIdxQ.push_back(eIdx);
    expPrioQ.push_back(ePrio);
    expTagQ.push_back(tag);
    // advance the reference state to after the edge
    mNmiPend = (n && !mNmiPrev) || (mNmiPend && !(eTake == 1 && eIdx == 1));
    mNmiPrev = n;
    mEn = (mEn | s) & ~c;
    if (we) begin
      if (addr == 0) mGlob = data[0];
      else if (addr == 1) mFault = data[0];
      else if (addr == 2) mThr = data & 8'hFF;
      else if (addr < NUM_IRQ + 3) mPrio[addr-3] = data & 8'hFF;
    end
  endtask

  task automatic req(input bit r, input bit n, input bit f, input bit [NUM_IRQ-1:0] irq,
                     input string tag);
    step(r, n, f, irq, '0, '0, 1'b0, 0, 0, tag);
  endtask

  task automatic wr(input int addr, input int data, input string tag);
    step(1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b1, addr, data, tag);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
  endtask

  // Monitor: compare one registered result per clock
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expTakeQ.size() > 0) begin
        int eT, eI, eP;
        string tg;
        eT = expTakeQ.pop_front();
        eI = expIdxQ.pop_front();
        eP = expPrioQ.pop_front();
        tg = expTagQ.pop_front();
        nTests++;
        if (int'(take) != eT || int'(winIdx) != eI || int'(winPrio) != eP) begin
          nFail++;
          $display("FAIL %s: take=%0d idx=%0d prio=%0d expected take=%0d idx=%0d prio=%0d",
                   tg, take, winIdx, int'(winPrio), eT, eI, eP);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R10: watchdog expired, actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    mEn = '0; mGlob = 0; mFault = 0; mThr = 0; mNmiPend = 0; mNmiPrev = 0;
    for (int k = 0; k < NUM_IRQ; k++) mPrio[k] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    nTests++;
    if (take !== 1'b0 || winIdx !== '0 || winPrio !== '0) begin
      nFail++;
      $display("FAIL R1: take=%0d idx=%0d prio=%0d expected 0 0 0", take, winIdx, int'(winPrio));
    end
    req(0, 0, 0, 8'hFF, "R1 enables clear after reset");
    step(0, 0, 0, '0, 8'hFF, '0, 1'b0, 0, 0, "R8 set all enables");
    // R11: line priorities
    wr(3, 5, "R11"); wr(4, 3, "R11"); wr(5, 7, "R11"); wr(6, 3, "R11");
    wr(7, 9, "R11"); wr(8, 200, "R11"); wr(9, 1, "R11"); wr(10, 0, "R11");
    req(0, 0, 0, 8'h06, "R3 smaller number wins");
    req(0, 0, 0, 8'h0A, "R4 tie goes to lowest index");
    req(0, 0, 0, 8'h18, "R3 priority 3 over 9");
    req(0, 0, 0, 8'hFF, "R3 all lines active");
    req(0, 0, 1, 8'hFF, "R2 fault beats lines");
    req(1, 0, 1, 8'hFF, "R2 reset beats all");
    // R9: edge-captured non-maskable interrupt
    req(0, 1, 1, 8'hFF, "R9 nmi not yet pending");
    req(0, 1, 1, 8'hFF, "R9 nmi taken");
    req(0, 1, 1, 8'hFF, "R9 held nmi not retaken");
    req(1, 1, 0, 8'h00, "R2 reset with nmi high");
    req(0, 0, 0, 8'h00, "R10 idle");
    req(0, 1, 0, 8'h00, "R9 new edge");
    req(1, 1, 0, 8'h00, "R2 reset over pending nmi");
    req(0, 1, 0, 8'h00, "R9 nmi kept pending");
    req(0, 0, 0, 8'h20, "R10 single line");
    req(0, 0, 0, 8'h20, "R10 take stays high");
    req(0, 0, 0, 8'h00, "R10 no source");
    // R5: global disable
    wr(0, 1, "R5");
    req(0, 0, 0, 8'hFF, "R5 lines blocked");
    req(0, 0, 1, 8'hFF, "R5 fault passes");
    wr(0, 0, "R5");
    req(0, 0, 0, 8'hFF, "R5 block lifted");
    // R6: fault-level disable
    wr(1, 1, "R6");
    req(0, 0, 1, 8'hFF, "R6 fault and lines blocked");
    req(0, 1, 1, 8'hFF, "R6 nmi edge");
    req(0, 1, 1, 8'hFF, "R6 nmi passes");
    req(1, 0, 1, 8'hFF, "R6 reset passes");
    wr(1, 0, "R6");
    req(0, 0, 1, 8'hFF, "R6 fault back");
    // R7: threshold
    wr(2, 3, "R7");
    req(0, 0, 0, 8'h0A, "R7 priority equal to limit blocked");
    req(0, 0, 0, 8'h4A, "R7 priority below limit passes");
    req(0, 0, 0, 8'h80, "R7 priority 0 passes");
    wr(2, 0, "R7");
    req(0, 0, 0, 8'h0A, "R7 zero threshold off");
    // R8: enable port details
    step(0, 0, 0, 8'h80, 8'h80, 8'h80, 1'b0, 0, 0, "R8 set and clear same bit");
    req(0, 0, 0, 8'h80, "R8 clear wins");
    req(0, 0, 0, 8'h80, "R8 zero writes keep clear");
    step(0, 0, 0, 8'h00, 8'h80, 8'h00, 1'b0, 0, 0, "R8 set again");
    req(0, 0, 0, 8'h80, "R8 enabled line taken");
    step(0, 0, 0, 8'h00, 8'h00, 8'h02, 1'b0, 0, 0, "R8 clear line 1");
    req(0, 0, 0, 8'h02, "R8 cleared line blocked");
    req(0, 0, 0, 8'h42, "R8 other lines unaffected");
    // R11: unused addresses
    wr(11, 255, "R11"); wr(15, 255, "R11");
    req(0, 0, 0, 8'h80, "R11 unused address ignored");
    req(0, 0, 0, 8'h0C, "R11 masks untouched");
    repeat (3) @(negedge clk);
    if (expTakeQ.size() != 0) begin
      nTests++; nFail++;
      $display("FAIL R10: %0d results missing, expected 0", expTakeQ.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule